// File: doc/BRIEF.md
# Multi-bank edge-interrupt GPIO controller

This block is a memory-mapped general-purpose I/O controller for 128 pins, split into four banks of 32. Each bank has eight 32-bit registers. Through them software reads the synchronized pin levels, sets output values and per-pin direction, picks which edges of which pins raise an interrupt, and collects and acknowledges pending events. The pending events of all banks are combined onto one interrupt request line.

The first three banks share one address region with their registers interleaved word by word. Bank b (b = 0, 1, 2) starts at byte offset 4·b. Bank 3 starts at offset 0x100. In every bank, register k sits at the bank base plus 12·k. The register port is a plain single-cycle port: the write takes effect at the clock edge where the write enable is high, and read data is a combinational function of the address. Only edges can cause interrupts; level-sensitive triggering does not exist.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pins_o` and `pins_oe_o` are all zero, `irq_o` is low, and every register reads zero while the pins are held low.
- R2: Addresses are byte offsets in an 0x800 window. Bank b < 3 register k is at 4·b + 12·k and bank 3 register k is at 0x100 + 12·k, for k = 0..7. Any other offset, including one with a nonzero low two bits, reads zero and ignores writes.
- R3: Register index 1 (data out) drives `pins_o` and index 2 (direction, 1 = output) drives `pins_oe_o` for the bank's 32 pins, bit n to pin 32·b + n. Both read back what was written and change only on a write to them or to index 7.
- R4: Register index 0 returns the bank's pin inputs through a two-flop synchronizer. A change applied before clock edge e is visible after edge e+1 and not after edge e alone. Writes to it are ignored.
- R5: A 0→1 change of a synchronized pin whose rising enable bit (index 3) is set sets that pin's pending bit (index 6).
- R6: A 1→0 change of a synchronized pin whose falling enable bit (index 4) is set sets that pin's pending bit. With both enables set, both directions set it.
- R7: A pin with neither enable set never sets its pending bit. A pin held steady at either level does not set its pending bit again after the bit is cleared.
- R8: Writing 1 to a bit of the pending register clears that bit and writing 0 leaves it unchanged. An edge detected in the same cycle as the clearing write leaves the bit set.
- R9: `irq_o` is high exactly while some bank has a pending bit whose bit in the interrupt allow register (index 5, 1 = forward) is set. Pending bits latch regardless of the allow register.
- R10: A write to register index 7 inverts the data-out bits where the written data is 1. Index 7 reads zero.
- R11: Each bank's registers and pending events are independent: writes and pin edges in one bank change no other bank's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 11 | Register byte offset |
| we_i | input | 1 | Write enable, write takes effect at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pins_i | input | 128 | Pin input levels, asynchronous |
| pins_o | output | 128 | Pin output values |
| pins_oe_o | output | 128 | Pin output enables |
| irq_o | output | 1 | Shared interrupt request |

## Verification
On every cycle, the assertions check that pending bits persist until a write-1 clears them, that a clear never beats a same-cycle edge, that no pending bit appears on a pin without an enabled edge, that the output values move only on writes aimed at them, and that stray writes leave the pins alone. The address arithmetic for both regions, the two-edge synchronizer latency, the edge polarity selected by each mix of enables, and the interrupt gating by the allow register can only be shown by the bench's sweeps over every bank and register offset. The same holds for bank independence.

// File: rtl/gpio_edge_pkg.sv
// Shared register indices for the edge-interrupt GPIO controller.
// Assumes eight registers per bank; the index order fixes the address order.
package gpio_edge_pkg;
    localparam int REGS_PER_BANK = 8;
    localparam int SEL_W         = 3;

    typedef enum logic [SEL_W-1:0] {
        RG_LEVEL = 3'd0,
        RG_DOUT  = 3'd1,
        RG_DIR   = 3'd2,
        RG_RISE  = 3'd3,
        RG_FALL  = 3'd4,
        RG_ALLOW = 3'd5,
        RG_PEND  = 3'd6,
        RG_FLIP  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
// Register address decoder.
// Maps a byte offset to (hit, bank, register). The first NUM_IL banks interleave
// word by word from offset 0 with a stride of NUM_IL words per register; the
// last bank starts at SOLO_BASE with the same stride. Unaligned offsets miss.
module gpio_addr_dec
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int NUM_IL    = 3,
    parameter int SOLO_BASE = 256,
    localparam int NB       = NUM_IL + 1,
    localparam int BW       = $clog2(NB)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [BW-1:0]     bank_o,
    output reg_sel_e          sel_o
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int IL_WORDS  = NUM_IL * REGS_PER_BANK;
    localparam int SOLO_WORD = SOLO_BASE / 4;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] off;

    assign word = addr_i[ADDR_W-1:2];
    assign off  = word - WORD_W'(SOLO_WORD);

    // Purpose: resolve the interleaved region or the separate last-bank region.
    always_comb begin
        hit_o  = 1'b0;
        bank_o = '0;
        sel_o  = RG_LEVEL;
        if (addr_i[1:0] == 2'b00) begin
            if (int'(word) < IL_WORDS) begin
                hit_o  = 1'b1;
                bank_o = BW'(int'(word) % NUM_IL);
                sel_o  = reg_sel_e'(SEL_W'(int'(word) / NUM_IL));
            end else if (int'(word) >= SOLO_WORD && int'(off) < IL_WORDS
                         && (int'(off) % NUM_IL) == 0) begin
                hit_o  = 1'b1;
                bank_o = BW'(NUM_IL);
                sel_o  = reg_sel_e'(SEL_W'(int'(off) / NUM_IL));
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One bank of PIN_W pins: synchronizer, edge detector, control and pending registers.
// Assumes wr_en is already qualified by the bank decode. Read data is combinational.
// Pending bits latch regardless of the allow register; a same-cycle edge beats a clear.
module gpio_bank
    import gpio_edge_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] rdata,
    output logic [PIN_W-1:0] dout,
    output logic [PIN_W-1:0] dir,
    output logic             irq_req
);
    logic [PIN_W-1:0] sync1_q, sync2_q, prev_q;
    logic [PIN_W-1:0] dout_q, dir_q, rise_q, fall_q, allow_q, pend_q;
    logic [PIN_W-1:0] set_vec, clr_mask;

    // Purpose: two-flop synchronizer plus one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pins_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Purpose: software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            allow_q <= '0;
        end else if (wr_en) begin
            case (sel)
                RG_DOUT:  dout_q  <= wdata;
                RG_FLIP:  dout_q  <= dout_q ^ wdata;
                RG_DIR:   dir_q   <= wdata;
                RG_RISE:  rise_q  <= wdata;
                RG_FALL:  fall_q  <= wdata;
                RG_ALLOW: allow_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: enabled edges of the synchronized pins and write-1 clear mask.
    always_comb begin
        set_vec  = (rise_q & sync2_q & ~prev_q) | (fall_q & ~sync2_q & prev_q);
        clr_mask = (wr_en && sel == RG_PEND) ? wdata : '0;
    end

    // Purpose: pending status; a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_vec;
    end

    // Purpose: register read mux.
    always_comb begin
        case (sel)
            RG_LEVEL: rdata = sync2_q;
            RG_DOUT:  rdata = dout_q;
            RG_DIR:   rdata = dir_q;
            RG_RISE:  rdata = rise_q;
            RG_FALL:  rdata = fall_q;
            RG_ALLOW: rdata = allow_q;
            RG_PEND:  rdata = pend_q;
            default:  rdata = '0;
        endcase
    end

    assign dout    = dout_q;
    assign dir     = dir_q;
    assign irq_req = |(pend_q & allow_q);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |=> ((~pend_q & $past(pend_q & ~clr_mask)) == '0)); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & clr_mask)) |=> ((pend_q & $past(set_vec & clr_mask)) == $past(set_vec & clr_mask))); // R8
    AST_NO_UNENABLED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_q | fall_q)) == '0)); // R7
    AST_DOUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == RG_DOUT || sel == RG_FLIP)) |=> $stable(dout_q)); // R3
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the multi-bank edge-interrupt GPIO controller.
// Assumes a single-cycle register port (write at the clock edge, combinational read)
// and asynchronous pin inputs. All bank interrupt requests share irq_o.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PIN_W     = 32,
    parameter int NUM_IL    = 3,
    parameter int SOLO_BASE = 256,
    localparam int NB       = NUM_IL + 1,
    localparam int BW       = $clog2(NB),
    localparam int TOTAL    = NB * PIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [PIN_W-1:0]  wdata_i,
    output logic [PIN_W-1:0]  rdata_o,
    input  logic [TOTAL-1:0]  pins_i,
    output logic [TOTAL-1:0]  pins_o,
    output logic [TOTAL-1:0]  pins_oe_o,
    output logic              irq_o
);
    logic             hit;
    logic [BW-1:0]    bank;
    reg_sel_e         sel;
    logic [PIN_W-1:0] bank_rd [NB];
    logic [NB-1:0]    bank_irq;

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_IL    (NUM_IL),
        .SOLO_BASE (SOLO_BASE)
    ) i_dec (
        .addr_i (addr_i),
        .hit_o  (hit),
        .bank_o (bank),
        .sel_o  (sel)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        gpio_bank #(.PIN_W(PIN_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_i  (pins_i[b*PIN_W +: PIN_W]),
            .wr_en   (we_i && hit && (int'(bank) == b)),
            .sel     (sel),
            .wdata   (wdata_i),
            .rdata   (bank_rd[b]),
            .dout    (pins_o[b*PIN_W +: PIN_W]),
            .dir     (pins_oe_o[b*PIN_W +: PIN_W]),
            .irq_req (bank_irq[b])
        );
    end

    // Purpose: select the addressed bank's read data, zero on a miss.
    always_comb begin
        rdata_o = hit ? bank_rd[bank] : '0;
    end

    assign irq_o = |bank_irq;

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit) |=> ($stable(pins_o) && $stable(pins_oe_o))); // R2
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [10:0]  addr = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] pins = '0;
    logic [127:0] pout, poe;
    logic         irq;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .pins_i(pins), .pins_o(pout), .pins_oe_o(poe), .irq_o(irq)
    );

    function automatic logic [10:0] ra(int b, int k);
        return 11'((b < 3 ? 4 * b : 256) + 12 * k);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(logic [10:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [10:0] a, output logic [31:0] d);
        addr = a;
        #2 d = rdata;
        @(negedge clk);
    endtask

    task automatic rdchk(string req, logic [10:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, r, f, t;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // R1: reset state
        chk("R1 pins_o", 32'(|pout), 32'd0);
        chk("R1 pins_oe_o", 32'(|poe), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++) rdchk("R1 reg reset", ra(b, k), 32'd0);

        // R2 R3: address map sweep with data-out and direction per bank
        for (int b = 0; b < 4; b++) begin
            wr(ra(b, 1), 32'hA5000000 ^ (32'(b + 1) * 32'h01010101));
            wr(ra(b, 2), 32'h0000C33C ^ (32'(b + 1) * 32'h00110011));
        end
        for (int b = 0; b < 4; b++) begin
            d = 32'hA5000000 ^ (32'(b + 1) * 32'h01010101);
            r = 32'h0000C33C ^ (32'(b + 1) * 32'h00110011);
            chk("R3 pins_o bank", pout[b*32 +: 32], d);
            chk("R3 pins_oe bank", poe[b*32 +: 32], r);
            rdchk("R2 dout readback", ra(b, 1), d);
            rdchk("R2 dir readback", ra(b, 2), r);
            rdchk("R11 allow untouched", ra(b, 5), 32'd0);
        end

        // R2: unmapped and unaligned offsets read zero, writes ignored
        begin
            logic [127:0] so, se;
            so = pout; se = poe;
            wr(11'h060, '1); wr(11'h104, '1); wr(11'h7FC, '1);
            wr(11'h001, '1); wr(11'h160, '1); wr(11'h10D, '1);
            chk("R2 stray write pins_o", 32'(pout != so), 32'd0);
            chk("R2 stray write pins_oe", 32'(poe != se), 32'd0);
            rdchk("R2 unmapped 0x060", 11'h060, 32'd0);
            rdchk("R2 unmapped 0x104", 11'h104, 32'd0);
            rdchk("R2 unmapped 0x7FC", 11'h7FC, 32'd0);
            rdchk("R2 unaligned 0x00D", 11'h00D, 32'd0);
            rdchk("R2 unmapped 0x160", 11'h160, 32'd0);
        end

        // R10: flip helper
        d = 32'hA5000000 ^ 32'h02020202;
        wr(ra(1, 7), 32'h0000FFFF);
        chk("R10 flip pins_o", pout[32 +: 32], d ^ 32'h0000FFFF);
        rdchk("R10 flip reads zero", ra(1, 7), 32'd0);
        chk("R11 flip other bank", pout[0 +: 32], 32'hA5000000 ^ 32'h01010101);

        // R4: synchronizer latency and read-only level register
        for (int b = 0; b < 4; b++) begin
            t = 32'h13579BDF ^ (32'(b) * 32'h11111111);
            pins[b*32 +: 32] = t;
            @(negedge clk);
            rdchk("R4 level after one edge", ra(b, 0), 32'd0);
            rdchk("R4 level after two edges", ra(b, 0), t);
            wr(ra(b, 0), '0);
            rdchk("R4 level write ignored", ra(b, 0), t);
            pins[b*32 +: 32] = '0;
            waitn(3);
        end

        // R5 R6 R7 R11: edge enables per pin, every bank
        for (int b = 0; b < 4; b++) begin
            r = 32'h9E3779B9 * 32'(b + 1);
            f = ~r ^ (32'h0000FFFF << b);
            t = 32'hDEADBEEF ^ (32'(b) * 32'h11111111);
            wr(ra(b, 3), r);
            wr(ra(b, 4), f);
            wr(ra(b, 6), '1);
            pins[b*32 +: 32] = t;
            waitn(4);
            rdchk("R5 rising pending", ra(b, 6), t & r);
            for (int o = 0; o < 4; o++)
                if (o != b) rdchk("R11 other bank pending", ra(o, 6), 32'd0);
            wr(ra(b, 6), '1);
            waitn(4);
            rdchk("R7 steady high no pending", ra(b, 6), 32'd0);
            pins[b*32 +: 32] = '0;
            waitn(4);
            rdchk("R6 falling pending", ra(b, 6), t & f);
            wr(ra(b, 6), '1);
            wr(ra(b, 3), '1);
            wr(ra(b, 4), '1);
            pins[b*32 +: 32] = 32'h0000FF00;
            waitn(4);
            pins[b*32 +: 32] = 32'h00000000;
            waitn(4);
            rdchk("R6 both edges", ra(b, 6), 32'h0000FF00);
            wr(ra(b, 6), '1);
            wr(ra(b, 3), '0);
            wr(ra(b, 4), '0);
            pins[b*32 +: 32] = 32'hFFFFFFFF;
            waitn(4);
            pins[b*32 +: 32] = 32'h00000000;
            waitn(4);
            rdchk("R7 no enable no pending", ra(b, 6), 32'd0);
        end

        // R9: interrupt gating by the allow register, bank 3 then bank 0
        wr(ra(3, 3), 32'h00000030);
        pins[96 +: 32] = 32'h00000030;
        waitn(4);
        chk("R9 masked pending no irq", 32'(irq), 32'd0);
        rdchk("R9 masked pending latched", ra(3, 6), 32'h00000030);
        wr(ra(3, 5), 32'h00000001);
        chk("R9 allow other bit no irq", 32'(irq), 32'd0);
        wr(ra(3, 5), 32'h00000020);
        chk("R9 allow raises irq", 32'(irq), 32'd1);
        wr(ra(3, 6), 32'h00000020);
        chk("R9 clear drops irq", 32'(irq), 32'd0);
        rdchk("R8 partial clear", ra(3, 6), 32'h00000010);
        wr(ra(3, 6), 32'h00000000);
        rdchk("R8 write zero keeps", ra(3, 6), 32'h00000010);
        wr(ra(3, 6), '1);
        wr(ra(0, 5), 32'h80000000);
        wr(ra(0, 4), 32'h80000000);
        pins[31] = 1'b1;
        waitn(4);
        chk("R9 rising not enabled", 32'(irq), 32'd0);
        pins[31] = 1'b0;
        waitn(4);
        chk("R9 falling irq bank0", 32'(irq), 32'd1);
        wr(ra(0, 6), '1);
        chk("R9 irq cleared", 32'(irq), 32'd0);

        // R8: edge in the same cycle as the clear keeps the bit
        wr(ra(2, 3), 32'h00000001);
        pins[64] = 1'b1;
        waitn(4);
        pins[64] = 1'b0;
        waitn(4);
        rdchk("R8 pending before clash", ra(2, 6), 32'h00000001);
        pins[64] = 1'b1;
        waitn(2);
        wr(ra(2, 6), 32'h00000001);
        rdchk("R8 edge beats clear", ra(2, 6), 32'h00000001);
        wr(ra(2, 6), 32'h00000001);
        rdchk("R8 clear without edge", ra(2, 6), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule